// File: doc/BRIEF.md
# Dual-Half Registered Bus Transceiver

This block joins two data buses, called A and B, through a pair of independent 8-bit halves. In each half, a capture register on each side can store the data seen on its own bus. Each output path then chooses between the live data arriving from the other bus and the value held in that side's register. An active-low enable and a direction control decide which bus a half drives, if it drives either. With the enable deasserted the half is isolated: neither bus is driven, but both registers still capture. This lets stored data be moved across while the buses carry other traffic.

The bidirectional pins are modelled as separate vectors: a data input, a data output and a per-bit output enable for each bus. The tri-state buffers themselves sit in the pad ring. The capture inputs are strobes, sampled by the block clock. A register loads on the first clock edge at which its strobe is seen high after having been low. Clearing is done by a synchronous active-low reset.

Top module: `dual_reg_xcvr`

## Requirements
- R1: The A-side register of a half loads that half's `a_in` byte on each clock edge where its `cap_ab` strobe is high and was low at the previous edge, whatever the values of `oe_n` and `dir`.
- R2: The B-side register of a half loads that half's `b_in` byte under the same rising-strobe rule, using `cap_ba`, whatever the values of `oe_n` and `dir`.
- R3: A strobe held high for several clock edges loads its register only once, at the first of those edges.
- R4: With `oe_n` high for a half, that half drives no bus: its bits of `a_oe`, `b_oe`, `a_out` and `b_out` are all zero, and captures still take place.
- R5: With `oe_n` low, `dir` = 1 sets the half's `b_oe` bits to all ones and its `a_oe` bits to zero. `dir` = 0 does the reverse. Within a half, the two buses are never driven together.
- R6: While B is driven and `sel_ab` = 0, the half's `b_out` equals its `a_in` in the same cycle, with no register delay.
- R7: While B is driven and `sel_ab` = 1, the half's `b_out` shows the A-side register. That value changes only at a capture edge.
- R8: While A is driven, `sel_ba` = 0 passes `b_in` live to `a_out`, and `sel_ba` = 1 shows the B-side register.
- R9: A capture taken while stored mode is selected appears on the driven output in the cycle after the capture edge.
- R10: Bits 7:0 obey control bit 0 and bits 15:8 obey control bit 1. Neither half is affected by the other half's controls.
- R11: A low `rst_n` at a clock edge clears both registers of both halves, and clears the strobe history, to zero.
- R12: The data output of a bus that is not driven reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_n | input | 2 | Active-low output enable, one bit per half |
| dir | input | 2 | Direction per half: 1 drives B, 0 drives A |
| sel_ab | input | 2 | B output source per half: 0 live A data, 1 A register |
| sel_ba | input | 2 | A output source per half: 0 live B data, 1 B register |
| cap_ab | input | 2 | A-register capture strobe per half |
| cap_ba | input | 2 | B-register capture strobe per half |
| a_in | input | 16 | Data seen on the A bus |
| a_out | output | 16 | Data to drive onto the A bus |
| a_oe | output | 16 | Per-bit drive enable for the A bus |
| b_in | input | 16 | Data seen on the B bus |
| b_out | output | 16 | Data to drive onto the B bus |
| b_oe | output | 16 | Per-bit drive enable for the B bus |

## Verification
The bench builds the block with its defaults: two halves of eight bits each. With that build, a single stimulus vector can give the halves opposite enables, directions and selects, so any leakage of control from one byte into the other would appear as a mismatch (R10). The eight-bit width lets distinct byte patterns make a wrong source (live against stored, A against B) visible in every bit. Directed cases cover a held strobe, capture while isolated, and a reset in mid-run.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Drive decode for one half: bit 1 enables the B bus, bit 0 the A bus.
  function automatic logic [1:0] drive_sel(input logic en_n, input logic to_b);
    logic [1:0] r;
    r[1] = !en_n && to_b;
    r[0] = !en_n && !to_b;
    return r;
  endfunction

  // A capture fires on a strobe seen high after having been low.
  function automatic logic rise_seen(input logic now_v, input logic last_v);
    return now_v && !last_v;
  endfunction

endpackage

// File: rtl/xcvr_strobe_cap.sv
module xcvr_strobe_cap #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             evt
);
  import xcvr_pkg::*;

  logic strobe_q;

  assign evt = rise_seen(strobe, strobe_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      q        <= '0;
    end else begin
      strobe_q <= strobe;
      if (evt) q <= din;
    end
  end
endmodule

// File: rtl/xcvr_out_path.sv
module xcvr_out_path #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  input  logic             use_stored,
  input  logic             drive,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] oe
);
  logic [WIDTH-1:0] picked;

  always_comb begin
    picked = use_stored ? stored : live;
    dout   = drive ? picked : '0;
    oe     = {WIDTH{drive}};
  end
endmodule

// File: rtl/xcvr_half.sv
module xcvr_half #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic             cap_ab,
  input  logic             cap_ba,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe,
  output logic             ab_evt,
  output logic             ba_evt
);
  import xcvr_pkg::*;

  logic [WIDTH-1:0] a_reg_q;
  logic [WIDTH-1:0] b_reg_q;
  logic [1:0]       drv;

  assign drv = drive_sel(oe_n, dir);

  xcvr_strobe_cap #(.WIDTH(WIDTH)) a_cap_i (
    .clk(clk), .rst_n(rst_n), .strobe(cap_ab), .din(a_in),
    .q(a_reg_q), .evt(ab_evt)
  );

  xcvr_strobe_cap #(.WIDTH(WIDTH)) b_cap_i (
    .clk(clk), .rst_n(rst_n), .strobe(cap_ba), .din(b_in),
    .q(b_reg_q), .evt(ba_evt)
  );

  xcvr_out_path #(.WIDTH(WIDTH)) to_b_i (
    .live(a_in), .stored(a_reg_q), .use_stored(sel_ab), .drive(drv[1]),
    .dout(b_out), .oe(b_oe)
  );

  xcvr_out_path #(.WIDTH(WIDTH)) to_a_i (
    .live(b_in), .stored(b_reg_q), .use_stored(sel_ba), .drive(drv[0]),
    .dout(a_out), .oe(a_oe)
  );
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr #(
  parameter int HALF_W     = 8,
  parameter int NUM_HALVES = 2,
  localparam int BUS_W     = HALF_W * NUM_HALVES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_HALVES-1:0] oe_n,
  input  logic [NUM_HALVES-1:0] dir,
  input  logic [NUM_HALVES-1:0] sel_ab,
  input  logic [NUM_HALVES-1:0] sel_ba,
  input  logic [NUM_HALVES-1:0] cap_ab,
  input  logic [NUM_HALVES-1:0] cap_ba,
  input  logic [BUS_W-1:0]      a_in,
  output logic [BUS_W-1:0]      a_out,
  output logic [BUS_W-1:0]      a_oe,
  input  logic [BUS_W-1:0]      b_in,
  output logic [BUS_W-1:0]      b_out,
  output logic [BUS_W-1:0]      b_oe
);
  // Capture events per half, brought out by name for the checker.
  logic [NUM_HALVES-1:0] ab_cap_evt;
  logic [NUM_HALVES-1:0] ba_cap_evt;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    xcvr_half #(.WIDTH(HALF_W)) half_i (
      .clk(clk), .rst_n(rst_n),
      .oe_n(oe_n[h]), .dir(dir[h]),
      .sel_ab(sel_ab[h]), .sel_ba(sel_ba[h]),
      .cap_ab(cap_ab[h]), .cap_ba(cap_ba[h]),
      .a_in(a_in[h*HALF_W +: HALF_W]), .b_in(b_in[h*HALF_W +: HALF_W]),
      .a_out(a_out[h*HALF_W +: HALF_W]), .a_oe(a_oe[h*HALF_W +: HALF_W]),
      .b_out(b_out[h*HALF_W +: HALF_W]), .b_oe(b_oe[h*HALF_W +: HALF_W]),
      .ab_evt(ab_cap_evt[h]), .ba_evt(ba_cap_evt[h])
    );
  end
endmodule

// File: rtl/dual_reg_xcvr_chk.sv
module dual_reg_xcvr_chk #(
  parameter int HALF_W     = 8,
  parameter int NUM_HALVES = 2,
  localparam int BUS_W     = HALF_W * NUM_HALVES
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_HALVES-1:0] oe_n,
  input logic [NUM_HALVES-1:0] dir,
  input logic [NUM_HALVES-1:0] sel_ab,
  input logic [NUM_HALVES-1:0] sel_ba,
  input logic [BUS_W-1:0]      a_in,
  input logic [BUS_W-1:0]      b_in,
  input logic [BUS_W-1:0]      a_out,
  input logic [BUS_W-1:0]      a_oe,
  input logic [BUS_W-1:0]      b_out,
  input logic [BUS_W-1:0]      b_oe,
  input logic [NUM_HALVES-1:0] ab_cap_evt,
  input logic [NUM_HALVES-1:0] ba_cap_evt
);
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_chk
    // R4, R12: isolation leaves both buses undriven and quiet
    assert_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n[h] |-> (a_oe[h*HALF_W +: HALF_W] == '0 && b_oe[h*HALF_W +: HALF_W] == '0 &&
                   a_out[h*HALF_W +: HALF_W] == '0 && b_out[h*HALF_W +: HALF_W] == '0));

    // R5: never both buses of one half at once
    assert_one_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !((|a_oe[h*HALF_W +: HALF_W]) && (|b_oe[h*HALF_W +: HALF_W])));

    // R5: enables are all ones or all zeros
    assert_oe_whole_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(b_oe[h*HALF_W +: HALF_W]) == 0 ||
       $countones(b_oe[h*HALF_W +: HALF_W]) == HALF_W));

    // R6: live path to B is combinational
    assert_live_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n[h] && dir[h] && !sel_ab[h]) |-> b_out[h*HALF_W +: HALF_W] == a_in[h*HALF_W +: HALF_W]);

    // R8: live path to A is combinational
    assert_live_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n[h] && !dir[h] && !sel_ba[h]) |-> a_out[h*HALF_W +: HALF_W] == b_in[h*HALF_W +: HALF_W]);

    // R9, R1: a capture shows up next cycle on a stored B output
    assert_cap_shows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ab_cap_evt[h] |=> ((!oe_n[h] && dir[h] && sel_ab[h]) |->
        b_out[h*HALF_W +: HALF_W] == $past(a_in[h*HALF_W +: HALF_W])));

    // R2, R9: same for the B register onto A
    assert_cap_ba_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ba_cap_evt[h] |=> ((!oe_n[h] && !dir[h] && sel_ba[h]) |->
        a_out[h*HALF_W +: HALF_W] == $past(b_in[h*HALF_W +: HALF_W])));

    // R7: without a capture the stored B output holds
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ab_cap_evt[h] && !oe_n[h] && dir[h] && sel_ab[h]) |=>
        ((!oe_n[h] && dir[h] && sel_ab[h]) |-> $stable(b_out[h*HALF_W +: HALF_W])));
  end
endmodule

bind dual_reg_xcvr dual_reg_xcvr_chk #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) chk_i (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
  .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
  .ab_cap_evt(ab_cap_evt), .ba_cap_evt(ba_cap_evt)
);

// File: tb/dual_reg_xcvr_tb_top.sv
module dual_reg_xcvr_tb_top;
  localparam int HW = 8;
  localparam int NH = 2;
  localparam int W  = HW * NH;
  localparam int NV = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic [NH-1:0] oe_n, dir, sel_ab, sel_ba, cap_ab, cap_ba;
  logic [W-1:0]  a_in, b_in, a_out, a_oe, b_out, b_oe;

  dual_reg_xcvr dut_i (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  // {oe_n, dir, sel_ab, sel_ba, cap_ab, cap_ba, a_in, b_in}
  localparam logic [43:0] VEC [NV] = '{
    {2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 16'h1234, 16'hABCD},
    {2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 16'h1234, 16'hABCD},
    {2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 16'h5A69, 16'h0000},
    {2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 16'hFFFF, 16'h0000},
    {2'b00, 2'b10, 2'b11, 2'b00, 2'b00, 2'b11, 16'h0F0F, 16'h7E81},
    {2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 16'h0000, 16'h0000},
    {2'b01, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 16'h0000, 16'h0000},
    {2'b10, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 16'hC3C3, 16'h9966},
    {2'b00, 2'b01, 2'b10, 2'b01, 2'b01, 2'b00, 16'h4422, 16'h1188},
    {2'b00, 2'b01, 2'b01, 2'b00, 2'b01, 2'b00, 16'h77EE, 16'h0000},
    {2'b11, 2'b11, 2'b00, 2'b00, 2'b10, 2'b01, 16'hBEEF, 16'hCAFE},
    {2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 16'h0000, 16'h0000}
  };

  int n_chk = 0;
  int n_bad = 0;

  // Bench-side view of the stored state, kept from the requirements.
  logic [HW-1:0] m_areg [NH];
  logic [HW-1:0] m_breg [NH];
  logic [NH-1:0] m_pab, m_pba;

  task automatic chk(input string req, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [W-1:0] ea, eao, eb, ebo;
    for (int h = 0; h < NH; h++) begin
      logic drv_b, drv_a;
      drv_b = !oe_n[h] && dir[h];
      drv_a = !oe_n[h] && !dir[h];
      eb[h*HW +: HW]  = drv_b ? (sel_ab[h] ? m_areg[h] : a_in[h*HW +: HW]) : '0;
      ea[h*HW +: HW]  = drv_a ? (sel_ba[h] ? m_breg[h] : b_in[h*HW +: HW]) : '0;
      ebo[h*HW +: HW] = {HW{drv_b}};
      eao[h*HW +: HW] = {HW{drv_a}};
    end
    chk(req, "a_out", a_out, ea);
    chk(req, "a_oe",  a_oe,  eao);
    chk(req, "b_out", b_out, eb);
    chk(req, "b_oe",  b_oe,  ebo);
  endtask

  // Check outputs before the edge, then advance the model across the edge.
  task automatic cycle(input string req);
    #2;
    check_all(req);
    @(posedge clk);
    if (!rst_n) begin
      for (int h = 0; h < NH; h++) begin
        m_areg[h] = '0;
        m_breg[h] = '0;
      end
      m_pab = '0;
      m_pba = '0;
    end else begin
      for (int h = 0; h < NH; h++) begin
        if (cap_ab[h] && !m_pab[h]) m_areg[h] = a_in[h*HW +: HW];
        if (cap_ba[h] && !m_pba[h]) m_breg[h] = b_in[h*HW +: HW];
      end
      m_pab = cap_ab;
      m_pba = cap_ba;
    end
    @(negedge clk);
  endtask

  task automatic drive(input logic [1:0] o, input logic [1:0] d, input logic [1:0] sab,
                       input logic [1:0] sba, input logic [1:0] cab, input logic [1:0] cba,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    oe_n = o; dir = d; sel_ab = sab; sel_ba = sba; cap_ab = cab; cap_ba = cba;
    a_in = a; b_in = b;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int h = 0; h < NH; h++) begin
      m_areg[h] = '0;
      m_breg[h] = '0;
    end
    m_pab = '0;
    m_pba = '0;
    rst_n = 1'b0;
    drive(2'b11, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 16'hFFFF, 16'hFFFF);
    @(negedge clk);
    cycle("R11");
    drive(2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 16'h0000, 16'h0000);
    cycle("R11");
    rst_n = 1'b1;

    // R11: reset state visible through the stored paths
    drive(2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 16'hFFFF, 16'hFFFF);
    #2; chk("R11", "b_out after reset", b_out, 16'h0000);
    cycle("R11");
    drive(2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 16'hFFFF, 16'hFFFF);
    #2; chk("R11", "a_out after reset", a_out, 16'h0000);
    cycle("R11");

    // Table walk: R1 R2 R5 R6 R7 R8 R9 R10 R12
    for (int i = 0; i < NV; i++) begin
      {oe_n, dir, sel_ab, sel_ba, cap_ab, cap_ba, a_in, b_in} = VEC[i];
      cycle("R1/R2/R5/R6/R7/R8/R10/R12 table");
    end
    // R10: last vector shows high half from isolated capture, low half from earlier one
    #2; chk("R10", "b_out per-half stored", b_out, 16'hBE22);

    // R3: strobe held high across two edges keeps the first value
    drive(2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 16'h1111, 16'h0000);
    cycle("R3");
    drive(2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 16'h2222, 16'h0000);
    cycle("R3");
    drive(2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 16'h3333, 16'h0000);
    #2; chk("R3", "b_out held strobe", b_out, 16'h1111);
    cycle("R3");

    // R4: capture while isolated, then reveal both registers
    drive(2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 16'hA5C3, 16'h3CA5);
    cycle("R4");
    drive(2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 16'h0000, 16'h0000);
    #2; chk("R4", "b_out isolated A capture", b_out, 16'hA5C3);
    cycle("R4");
    drive(2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 16'h0000, 16'h0000);
    #2; chk("R4", "a_out isolated B capture", a_out, 16'h3CA5);
    cycle("R4");

    // R9: capture in stored mode, old value before the edge, new after
    drive(2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b11, 16'h0000, 16'h6D4B);
    #2; chk("R9", "a_out before capture", a_out, 16'h3CA5);
    cycle("R9");
    drive(2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 16'h0000, 16'h0000);
    #2; chk("R9", "a_out after capture", a_out, 16'h6D4B);
    cycle("R9");

    // R11: reset in mid-run clears stored values
    rst_n = 1'b0;
    cycle("R11");
    rst_n = 1'b1;
    drive(2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 16'h0000, 16'hFFFF);
    #2; chk("R11", "a_out after mid reset", a_out, 16'h0000);
    cycle("R11");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule